// File: doc/BRIEF.md
# Long-Press Push-Button Reset Generator

This block turns a deliberate, long hold of one or two active-low push buttons into a system reset. Short taps are for other user functions and must never reset the system, so the block asserts its active-low reset output only after the qualifying button condition has held without a break for a setup delay. A strap-style select input picks one of two delay lengths. The inputs are taken as already synchronized to the clock.

An elaboration parameter chooses how the reset ends. It either lasts a fixed number of cycles whatever the buttons do, or it lasts until a button is released. A second parameter chooses between two-button and one-button monitoring. A latched output flips on every completed reset pulse, so it can act as an on/off level that changes only on a long press. A clear input sets that output to a known level at power-up. All delay and pulse lengths are counted in clock cycles. The defaults correspond to seconds at a 32.768 kHz clock.

Top module: `lp_reset_gen`

## Requirements
- R1: With the buttons held in the qualifying condition for fewer than the selected delay's number of consecutive clock edges, `rst_n_o` stays 1. It goes to 0 right after the edge that completes the delay count.
- R2: `dly_sel_i` = 0 selects a delay of `SHORT_DLY` cycles, and `dly_sel_i` = 1 selects `LONG_DLY` cycles.
- R3: With `HOLD_MODE` = 0, `rst_n_o` stays 0 for exactly `PULSE_LEN` cycles, no matter what the buttons do during the pulse.
- R4: With `HOLD_MODE` = 1, `rst_n_o` stays 0 while the buttons remain in the qualifying condition. It returns to 1 one edge after that condition ends. With two buttons, one button going high ends it.
- R5: With `DUAL` = 1, the qualifying condition is both buttons at 0. Either button at 1 before the delay completes restarts the count from zero.
- R6: With `DUAL` = 1 and `btn_b_n_i` tied to 0, the block responds to `btn_a_n_i` alone, as a one-button block would.
- R7: After a fixed-length pulse, no new reset starts until the buttons have left the qualifying condition and then held it again for a full delay.
- R8: `latch_q_o` inverts on every 0-to-1 transition of `rst_n_o`.
- R9: `latch_clr_i` = 1 sets `latch_q_o` to 0 on the next edge. The clear takes priority over a toggle on the same edge.
- R10: The synchronous reset `rst_i` clears the counters, sets `rst_n_o` to 1 (released) and sets `latch_q_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| latch_clr_i | input | 1 | Clears the latched output to 0 |
| dly_sel_i | input | 1 | Delay select: 0 short, 1 long; held static |
| btn_a_n_i | input | 1 | First button, active low, synchronized |
| btn_b_n_i | input | 1 | Second button, active low; ignored when DUAL = 0 |
| rst_n_o | output | 1 | Reset, 0 = drive low, 1 = released to the pull-up |
| latch_q_o | output | 1 | Level that toggles on each completed reset |

## Verification
The assertions assume that `dly_sel_i` does not change while a delay is counting. They also assume that the buttons come in clean and synchronous, so one sampled level per edge is the real button state. The stimulus changes the select only while the buttons are released. It drives buttons and clear only at falling clock edges. Three instances share the stimulus: two-button fixed-pulse, two-button hold, and one-button fixed-pulse. The bench sweeps every press length up to the delay for both select values and computes, for each instance, the exact cycle in which the output must change.

// File: rtl/lp_reset_gen.sv
module lp_reset_gen #(
  parameter int DUAL      = 1,
  parameter int HOLD_MODE = 0,
  parameter int SHORT_DLY = 196608,
  parameter int LONG_DLY  = 327680,
  parameter int PULSE_LEN = 10486
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic latch_clr_i,
  input  logic dly_sel_i,
  input  logic btn_a_n_i,
  input  logic btn_b_n_i,
  output logic rst_n_o,
  output logic latch_q_o
);

  localparam int MAXC = (SHORT_DLY > LONG_DLY ? SHORT_DLY : LONG_DLY) > PULSE_LEN ?
                        (SHORT_DLY > LONG_DLY ? SHORT_DLY : LONG_DLY) : PULSE_LEN;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_DLY - 1);
  localparam logic [CW-1:0] PULSE_M1 = CW'(PULSE_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_FIRE, S_WAIT} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          pressed;
  logic          fire_end;
  logic [CW-1:0] dly_lim;

  if (DUAL != 0) begin : g_dual
    assign pressed = !btn_a_n_i && !btn_b_n_i;
  end else begin : g_single
    logic unused_b;
    assign unused_b = btn_b_n_i;
    assign pressed  = !btn_a_n_i;
  end

  assign dly_lim  = dly_sel_i ? LONG_M1 : SHORT_M1;
  assign fire_end = (state == S_FIRE) &&
                    ((HOLD_MODE != 0) ? !pressed : (cnt == PULSE_M1));
  assign rst_n_o  = (state != S_FIRE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (!pressed) cnt <= '0;
          else if (cnt == dly_lim) begin
            state <= S_FIRE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_FIRE: begin
          if (fire_end) begin
            cnt   <= '0;
            state <= (pressed && HOLD_MODE == 0) ? S_WAIT : S_IDLE;
          end else if (HOLD_MODE == 0) cnt <= cnt + 1'b1;
        end
        S_WAIT: if (!pressed) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || latch_clr_i) latch_q_o <= 1'b0;
    else if (fire_end)        latch_q_o <= !latch_q_o;
  end

  a_r1_full_delay: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_n_o) |-> $past(pressed) && ($past(cnt) == $past(dly_lim)));

  a_r8_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(rst_n_o) && !$past(latch_clr_i) && !$past(rst_i) |-> latch_q_o != $past(latch_q_o));

  a_r9_clear: assert property (@(posedge clk_i)
    $past(latch_clr_i) |-> !latch_q_o);

  a_r10_reset: assert property (@(posedge clk_i)
    $past(rst_i) |-> rst_n_o && !latch_q_o && cnt == '0);

  if (HOLD_MODE != 0) begin : g_hold_chk
    a_r4_stay: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_n_o && pressed |=> !rst_n_o);
    a_r4_release: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_n_o && !pressed |=> rst_n_o);
  end else begin : g_fixed_chk
    a_r3_pulse_len: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(rst_n_o) && !$past(rst_i) |-> $past(cnt) == PULSE_M1);
    a_r7_no_retrigger: assert property (@(posedge clk_i) disable iff (rst_i)
      state == S_WAIT |=> rst_n_o);
  end

endmodule

// File: tb/lp_reset_gen_bench.sv
`timescale 1ns/100ps
module lp_reset_gen_bench;
  localparam int SD = 8;
  localparam int LD = 14;
  localparam int PL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, clr = 1'b0, sel = 1'b0, a = 1'b1, b = 1'b1;
  logic [2:0] rn, lq;
  logic [2:0] lx = 3'b000;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  lp_reset_gen #(.DUAL(1), .HOLD_MODE(0), .SHORT_DLY(SD), .LONG_DLY(LD), .PULSE_LEN(PL)) u_lp_reset_gen (
    .clk_i(clk), .rst_i(rst), .latch_clr_i(clr), .dly_sel_i(sel),
    .btn_a_n_i(a), .btn_b_n_i(b), .rst_n_o(rn[0]), .latch_q_o(lq[0]));
  lp_reset_gen #(.DUAL(1), .HOLD_MODE(1), .SHORT_DLY(SD), .LONG_DLY(LD), .PULSE_LEN(PL)) u_lp_reset_gen_hold (
    .clk_i(clk), .rst_i(rst), .latch_clr_i(clr), .dly_sel_i(sel),
    .btn_a_n_i(a), .btn_b_n_i(b), .rst_n_o(rn[1]), .latch_q_o(lq[1]));
  lp_reset_gen #(.DUAL(0), .HOLD_MODE(0), .SHORT_DLY(SD), .LONG_DLY(LD), .PULSE_LEN(PL)) u_lp_reset_gen_single (
    .clk_i(clk), .rst_i(rst), .latch_clr_i(clr), .dly_sel_i(sel),
    .btn_a_n_i(a), .btn_b_n_i(b), .rst_n_o(rn[2]), .latch_q_o(lq[2]));

  function automatic logic exp_rn(int j, int d, bit hold);
    if (hold) return !(j >= d);
    return !(j >= d && j < d + PL);
  endfunction

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_latches(string req);
    for (int i = 0; i < 3; i++) chk(lq[i], lx[i], req, $sformatf("latch inst%0d", i));
  endtask

  task automatic long_press(logic s);
    int d;
    d = s ? LD : SD;
    sel = s; a = 1'b0; b = 1'b0;
    for (int j = 1; j <= 2*d + PL + 2; j++) begin
      @(negedge clk);
      chk(rn[0], exp_rn(j, d, 0), "R3_R7_R2", $sformatf("dual fixed j=%0d", j));
      chk(rn[1], exp_rn(j, d, 1), "R4_R2", $sformatf("dual hold j=%0d", j));
      chk(rn[2], exp_rn(j, d, 0), "R3_R1", $sformatf("single j=%0d", j));
    end
    a = 1'b1; b = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) chk(rn[i], 1'b1, "R4", $sformatf("after release inst%0d", i));
    lx = ~lx;
    chk_latches("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) chk(rn[i], 1'b1, "R10", "reset output level");
    chk_latches("R10");

    // R1, R2: sweep every too-short press for both delays
    for (int s = 0; s < 2; s++) begin
      sel = s[0];
      for (int L = 1; L < (s == 1 ? LD : SD); L++) begin
        a = 1'b0; b = 1'b0;
        for (int j = 1; j <= L; j++) begin
          @(negedge clk);
          for (int i = 0; i < 3; i++) chk(rn[i], 1'b1, "R1", $sformatf("short L=%0d sel=%0d", L, s));
        end
        a = 1'b1; b = 1'b1;
        repeat (2) begin
          @(negedge clk);
          for (int i = 0; i < 3; i++) chk(rn[i], 1'b1, "R1", "after short release");
        end
      end
    end

    long_press(1'b0);
    long_press(1'b1);

    // R5: second button glitches high; dual instances restart
    sel = 1'b0; a = 1'b0; b = 1'b0;
    for (int j = 1; j <= 14; j++) begin
      @(negedge clk);
      chk(rn[0], 1'b1, "R5", $sformatf("restart fixed j=%0d", j));
      chk(rn[1], 1'b1, "R5", $sformatf("restart hold j=%0d", j));
      chk(rn[2], exp_rn(j, SD, 0), "R5", $sformatf("single ignores b j=%0d", j));
      if (j == 6) b = 1'b1;
      if (j == 7) b = 1'b0;
    end
    a = 1'b1; b = 1'b1;
    repeat (2) @(negedge clk);
    lx[2] = ~lx[2];
    chk_latches("R8");

    // R6: b tied low, a alone drives; R4 released by one input
    b = 1'b0; a = 1'b0;
    for (int j = 1; j <= SD + PL + 1; j++) begin
      @(negedge clk);
      chk(rn[0], exp_rn(j, SD, 0), "R6", $sformatf("tied fixed j=%0d", j));
      chk(rn[1], exp_rn(j, SD, 1), "R6", $sformatf("tied hold j=%0d", j));
      chk(rn[2], exp_rn(j, SD, 0), "R6", $sformatf("single j=%0d", j));
    end
    a = 1'b1;
    @(negedge clk);
    chk(rn[1], 1'b1, "R4", "one input high ends hold");
    b = 1'b1;
    @(negedge clk);
    lx = ~lx;
    chk_latches("R8");

    // R10: reset during an active pulse
    a = 1'b0; b = 1'b0;
    repeat (SD) @(negedge clk);
    for (int i = 0; i < 3; i++) chk(rn[i], 1'b0, "R1", "pulse before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; a = 1'b1; b = 1'b1;
    for (int i = 0; i < 3; i++) chk(rn[i], 1'b1, "R10", "reset mid pulse");
    lx = 3'b000;
    chk_latches("R10");
    @(negedge clk);

    // R9: clear after setting latches
    long_press(1'b0);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    lx = 3'b000;
    chk_latches("R9");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule